// File: doc/BRIEF.md
# GPIO Interrupt Cause Aggregator

This block holds the interrupt logic for a bank of GPIO pins (32 by default). Its inputs are pin levels that have already been synchronised and polarity-corrected upstream, so whether a pin reacts to a rising or a falling line is chosen before it reaches this block. Each pin can raise an interrupt in one of two ways:

- A level request follows the corrected input directly, with nothing latched.
- An edge request comes from a sticky cause bit. A rising transition of the corrected input sets the bit.

A small register interface gives software access to three registers:

| Offset | Register | Role |
|--------|----------|------|
| 0x00 | edge cause | the latched edge events |
| 0x04 | edge mask | enables edge requests per pin |
| 0x08 | level mask | enables level requests per pin |

Software acknowledges an edge event by writing the cause register with a 0 in that bit. The masked per-pin requests are ORed in groups of eight consecutive pins. This gives one registered request line per group, which goes to a main interrupt controller.

The register port is a plain single-cycle write strobe with a combinational read. It has no valid/ready stream and never applies back-pressure: every write is accepted in the cycle it is presented.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset, the edge cause, edge mask and level mask registers all read 0, and every group output is 0.
- R2: A write to offset 0x04 loads the edge mask, and a write to offset 0x08 loads the level mask. Each reads back what was written. Any other offset except 0x00 reads 0, and a write to it changes no register.
- R3: When the corrected input of pin i is sampled 1 after being 0 at the previous clock edge, bit i of the edge cause (offset 0x00) is set. A falling transition sets nothing.
- R4: An edge cause bit stays set after its pin returns low, until software clears it.
- R5: A write to offset 0x00 clears every cause bit written as 0 and leaves every bit written as 1 unchanged. Writing 1 never sets a bit.
- R6: If a rising transition and a clearing write hit the same cause bit in the same cycle, the bit ends set.
- R7: The level request of pin i is its corrected input AND level mask bit i. It is not latched, so the group output falls again once the pin goes low.
- R8: The edge request of pin i is cause bit i AND edge mask bit i. A cause bit whose mask bit is 0 raises no request but stays readable.
- R9: Group output g is the OR of the requests of pins 8g to 8g+7.
- R10: Group outputs are registered. A level request sampled at a clock edge appears on its group output just after that same edge. An edge request appears one edge later, once the cause bit has been latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset, asynchronous |
| pin_lvl | input | 32 | synchronised, polarity-corrected pin levels |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 4 | register byte offset |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | read data for reg_addr |
| grp_irq | output | 4 | registered request line per group of eight pins |

## Verification
A wrong cause bit shows up at the ports in two ways. It reads back at offset 0x00 right after the offending edge, and it drives its group output one edge later when the bit is unmasked. A lost or spurious event is therefore visible within two cycles. A mask bit stored wrongly either shows in its readback at once, or misroutes a request to a group output on the next edge. The bench checks cause and group together after each step of pin stimulus, so one bad bit is caught through both paths.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned NPINS   = 32;
  localparam int unsigned GRP_SZ  = 8;
  localparam int unsigned NGRP    = NPINS / GRP_SZ;
  localparam int unsigned ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_CAUSE = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_EMASK = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_LMASK = 4'h8;
endpackage

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_keep,
  output logic [N-1:0] cause_q
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise_w;
  logic [N-1:0] clr_w;

  assign rise_w = lvl & ~prev_q;
  assign clr_w  = clr_wr ? ~clr_keep : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= lvl;
      cause_q <= (cause_q & ~clr_w) | rise_w;
    end
  end

  // R3 R6
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w != '0) |=> ((cause_q & $past(rise_w)) == $past(rise_w)));

  // R4
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q != '0) |=> (($past(cause_q) & ~$past(clr_w) & ~cause_q) == '0));

  // R5
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w == '0) |=> ((cause_q & ~$past(cause_q)) == '0));
endmodule

// File: rtl/gpio_mask_regs.sv
module gpio_mask_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      emask_q,
  output logic [N-1:0]      lmask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emask_q <= '0;
      lmask_q <= '0;
    end else if (wr) begin
      if (addr == OFS_EMASK) emask_q <= wdata;
      if (addr == OFS_LMASK) lmask_q <= wdata;
    end
  end

  // R2
  emask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_EMASK) |=> (emask_q == $past(wdata)));

  // R2
  lmask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr != OFS_LMASK) |=> $stable(lmask_q));
endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
  parameter int unsigned N     = 32,
  parameter int unsigned GSZ   = 8,
  localparam int unsigned NG   = N / GSZ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [NG-1:0] grp_q
);
  logic [NG-1:0] grp_d;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_d[g] = |req[g*GSZ +: GSZ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_q <= '0;
    else        grp_q <= grp_d;
  end

  // R9 R10
  idle_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (grp_q == '0));
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  output logic [NGRP-1:0]   grp_irq
);
  logic [NPINS-1:0] cause_q, emask_q, lmask_q, req_w;

  gpio_edge_latch #(.N(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pin_lvl),
    .clr_wr(reg_wr && reg_addr == OFS_CAUSE),
    .clr_keep(reg_wdata), .cause_q(cause_q)
  );

  gpio_mask_regs #(.N(NPINS)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .emask_q(emask_q), .lmask_q(lmask_q)
  );

  // R7 R8
  assign req_w = (pin_lvl & lmask_q) | (cause_q & emask_q);

  gpio_group_or #(.N(NPINS), .GSZ(GRP_SZ)) u_grp (
    .clk(clk), .rst_n(rst_n), .req(req_w), .grp_q(grp_irq)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_CAUSE: reg_rdata = cause_q;
      OFS_EMASK: reg_rdata = emask_q;
      OFS_LMASK: reg_rdata = lmask_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (grp_irq == '0 || rst_n));
endmodule

// File: tb/tb_gpio_irq_agg.sv
module tb_gpio_irq_agg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] pin_lvl = '0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  grp_irq;

  int n_chk = 0, n_bad = 0;

  gpio_irq_agg dut (.clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grp_irq(grp_irq));

  always #5 clk = ~clk;

  localparam logic [31:0] LMASK = 32'h0000_00FF;
  localparam logic [31:0] EMASK = 32'hFFFF_0000;

  // {pins, expected cause, expected groups}, checked two edges after driving
  localparam logic [67:0] VEC [7] = '{
    {32'h0000_0000, 32'h0000_0000, 4'b0000},
    {32'h0000_0001, 32'h0000_0001, 4'b0001},
    {32'h0000_0000, 32'h0000_0001, 4'b0000},
    {32'h0001_0000, 32'h0001_0001, 4'b0100},
    {32'h0000_0000, 32'h0001_0001, 4'b0100},
    {32'h8000_0100, 32'h8001_0101, 4'b1100},
    {32'h0000_0000, 32'h8001_0101, 4'b1100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 grp", {28'd0, grp_irq}, 0);
    rd(4'h0, r); chk("R1 cause", r, 0);
    rd(4'h4, r); chk("R1 emask", r, 0);
    rd(4'h8, r); chk("R1 lmask", r, 0);
    @(negedge clk); rst_n = 1;

    // R2
    wr(4'h4, EMASK);
    wr(4'h8, LMASK);
    wr(4'hC, 32'hDEAD_BEEF);
    rd(4'h4, r); chk("R2 emask", r, EMASK);
    rd(4'h8, r); chk("R2 lmask", r, LMASK);
    rd(4'hC, r); chk("R2 unmapped", r, 0);

    // R3 R4 R7 R8 R9 table walk
    foreach (VEC[i]) begin
      @(negedge clk); pin_lvl = VEC[i][67:36];
      @(posedge clk); @(posedge clk);
      rd(4'h0, r); chk("R3/R4 cause", r, VEC[i][35:4]);
      chk("R7/R8/R9 grp", {28'd0, grp_irq}, {28'd0, VEC[i][3:0]});
    end

    // R5: clear bit16 only, then writing ones changes nothing
    wr(4'h0, 32'hFFFE_FFFF);
    rd(4'h0, r); chk("R5 clear", r, 32'h8000_0101);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, r); chk("R5 ones", r, 32'h8000_0101);
    @(posedge clk); #1;
    chk("R5 grp", {28'd0, grp_irq}, 32'h8);

    // R6: rise on bit17 together with clearing write of bit17
    @(negedge clk); pin_lvl = 32'h0002_0000;
    reg_wr = 1; reg_addr = 4'h0; reg_wdata = 32'hFFFD_FFFF;
    @(posedge clk); #1 reg_wr = 0;
    rd(4'h0, r); chk("R6 set wins", r, 32'h8002_0101);

    // R8: masked cause readable but raises nothing
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0);
    @(negedge clk); pin_lvl = 32'h0003_0000;
    repeat (3) @(posedge clk); #1;
    chk("R8 masked grp", {28'd0, grp_irq}, 0);
    rd(4'h0, r); chk("R8 masked cause", r, 32'h0001_0000);

    // R10: level request appears just after the edge that samples it
    @(negedge clk); pin_lvl = 32'h0000_0004;
    #1 chk("R10 before edge", {28'd0, grp_irq}, 0);
    @(posedge clk); #1;
    chk("R10 after edge", {28'd0, grp_irq}, 32'h1);
    // R7: not latched
    @(negedge clk); pin_lvl = 32'h0;
    @(posedge clk); #1;
    chk("R7 level drops", {28'd0, grp_irq}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule